// File: doc/BRIEF.md
# Branch Trace Synchronization Controller

This block watches a processor's taken changes of program flow and turns each one into a branch trace message record. Each record is one of two forms. A sync message carries the whole target address with leading zero bits trimmed, and that target becomes the new reference address. A normal message carries only the low target bits up to the highest bit that differs from the reference. Each record also reports how many sequential instructions ran since the previous message, and a type code that gives the branch kind.

A sync is never produced on demand. Several causes can request one: event-in, a watchpoint hit, a trace queue overrun, a wrap of the sequential-instruction counter, a change of compressed-code mode, an explicit request pulse, and the start of tracing. Each cause only sets a pending flag. The flag is consumed by the next taken change of flow, and that message goes out as a sync. Messages are registered, so a change of flow seen at one clock edge shows up on the outputs for one cycle after that edge.

Top module: `brtrace_sync_ctrl`

## Requirements
- R1: During reset and after it, `msg_valid` is low until a change of flow occurs. The first message after reset is a sync.
- R2: A sync message has `msg_addr` equal to the full target. `msg_len` is one more than the index of the target's highest set bit, or 0 for a zero target. The target becomes the reference address.
- R3: A normal message has `msg_len` equal to one more than the index of the highest bit where the target differs from the reference, or 0 if the two are equal. `msg_addr` holds the target's bits below `msg_len`, and all higher bits of `msg_addr` are zero.
- R4: A sync cause raised in the same cycle as a change of flow does not make that message a sync. It makes the following message a sync.
- R5: An event-in pulse requests a sync only when `evt_ctrl` equals 2'b00 and `unit_off` is low. Otherwise it has no effect.
- R6: A watchpoint pulse while `trace_en` is high requests a sync.
- R7: A trace queue overrun pulse requests a sync.
- R8: The sequential counter holds up to MAXSEQ-1 (255 by default). The MAXSEQ-th strobe without an intervening message wraps the counter to 0 and requests a sync.
- R9: Any change of the `cmode` level, rising or falling, requests a sync.
- R10: A `sync_req` pulse makes the next change-of-flow message a sync.
- R11: While `trace_en` is low, no message is emitted. After `trace_en` rises, the first message is a sync.
- R12: `msg_type` is {sync, compressed, indirect}. Bit 2 is 1 for a sync. Bit 1 copies `cof_comp`. Bit 0 copies `cof_indirect`.
- R13: `msg_count` is the number of strobes accepted before the change-of-flow cycle since the previous message. A strobe in the change-of-flow cycle counts toward the next message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trace_en | input | 1 | Program trace enable (level) |
| unit_off | input | 1 | Trace unit disabled; blocks event-in |
| evt_ctrl | input | 2 | Event-in control; 2'b00 lets event-in request a sync |
| evt_in | input | 1 | Event-in pulse |
| wpt_hit | input | 1 | Watchpoint hit pulse |
| q_overrun | input | 1 | Trace queue overrun pulse |
| cmode | input | 1 | Compressed-code mode level |
| sync_req | input | 1 | Explicit sync request pulse |
| seq_strobe | input | 1 | One sequential instruction executed |
| cof_valid | input | 1 | Taken change of flow this cycle |
| cof_indirect | input | 1 | Change of flow is indirect |
| cof_comp | input | 1 | Change of flow is in compressed code |
| cof_target | input | AW | Branch target address |
| msg_valid | output | 1 | Message record valid (one cycle) |
| msg_type | output | 3 | {sync, compressed, indirect} |
| msg_addr | output | AW | Trimmed address bits |
| msg_len | output | $clog2(AW+1) | Number of significant address bits |
| msg_count | output | $clog2(MAXSEQ) | Sequential instructions since the previous message |

## Verification
The hardest case to reach is the counter wrap. It needs exactly MAXSEQ strobes with no message in between, and it must be told apart from the MAXSEQ-1 case, which must stay a normal message with count 255. The stimulus therefore emits a normal message first so the counter and pending flag start clear. It then holds the strobe for 255 edges and emits a change of flow, then repeats with 256 edges. The same-cycle cases (a request or a strobe arriving with the change of flow) are driven in one cycle to show that they apply only to the following message.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;

   // Branch kind, stored in the low two bits of the message type
   typedef enum logic [1:0] {
      KIND_DIR  = 2'b00,
      KIND_IND  = 2'b01,
      KIND_DIRC = 2'b10,
      KIND_INDC = 2'b11
   } cof_kind_e;

   function automatic logic [2:0] make_type(input logic is_sync, input cof_kind_e kind);
      return {is_sync, kind};
   endfunction

endpackage

// File: rtl/brtrace_seq_cnt.sv
module brtrace_seq_cnt #(
   parameter int MAXSEQ = 256,
   parameter int CW     = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          strobe,
   input  logic          clr,
   output logic [CW-1:0] cnt,
   output logic          wrap
);
   localparam logic [CW-1:0] TOP = CW'(MAXSEQ - 1);

   logic [CW-1:0] cnt_q;

   assign wrap = en & ~clr & strobe & (cnt_q == TOP);
   assign cnt  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!en)     cnt_q <= '0;
      else if (clr)     cnt_q <= strobe ? CW'(1) : '0;
      else if (wrap)    cnt_q <= '0;
      else if (strobe)  cnt_q <= cnt_q + CW'(1);
   end

   // R8: a wrap leaves the counter at zero
   p_wrap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> cnt_q == '0);

endmodule

// File: rtl/brtrace_sync_pend.sv
module brtrace_sync_pend (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trace_en,
   input  logic       unit_off,
   input  logic [1:0] evt_ctrl,
   input  logic       evt_in,
   input  logic       wpt_hit,
   input  logic       q_overrun,
   input  logic       cmode,
   input  logic       sync_req,
   input  logic       seq_wrap,
   input  logic       emit,
   output logic       pend
);
   logic pend_q, cmode_q, en_q;
   logic [6:0] cause;

   always_comb begin
      cause[0] = evt_in & (evt_ctrl == 2'b00) & ~unit_off;
      cause[1] = wpt_hit & trace_en;
      cause[2] = q_overrun;
      cause[3] = seq_wrap;
      cause[4] = cmode ^ cmode_q;
      cause[5] = sync_req;
      cause[6] = trace_en & ~en_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b1;
         cmode_q <= 1'b0;
         en_q    <= 1'b0;
      end else begin
         pend_q  <= (pend_q & ~emit) | (|cause);
         cmode_q <= cmode;
         en_q    <= trace_en;
      end
   end

   assign pend = pend_q;

   // R10: an explicit request is always held pending
   p_req_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sync_req |=> pend_q);

   // R9: a mode change in either direction leaves a pending sync
   p_cmode_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmode != cmode_q) |=> pend_q);

   // R7: overrun leaves a pending sync
   p_ovr_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      q_overrun |=> pend_q);

endmodule

// File: rtl/brtrace_addr_trim.sv
module brtrace_addr_trim #(
   parameter int AW = 32,
   parameter int LW = 6
) (
   input  logic [AW-1:0] val,
   input  logic [AW-1:0] tgt,
   output logic [LW-1:0] len,
   output logic [AW-1:0] addr
);
   // pre[i] is set when val has a one at bit i or above
   logic [AW-1:0] pre;

   for (genvar i = 0; i < AW; i++) begin : g_pre
      if (i == AW - 1) begin : g_top
         assign pre[i] = val[i];
      end else begin : g_chain
         assign pre[i] = val[i] | pre[i+1];
      end
   end

   always_comb begin
      len = '0;
      for (int i = 0; i < AW; i++) len = len + LW'(pre[i]);
   end

   assign addr = tgt & pre;

endmodule

// File: rtl/brtrace_sync_ctrl.sv
module brtrace_sync_ctrl
   import brtrace_pkg::*;
#(
   parameter  int AW     = 32,
   parameter  int MAXSEQ = 256,
   localparam int LW     = $clog2(AW + 1),
   localparam int CW     = $clog2(MAXSEQ)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trace_en,
   input  logic          unit_off,
   input  logic [1:0]    evt_ctrl,
   input  logic          evt_in,
   input  logic          wpt_hit,
   input  logic          q_overrun,
   input  logic          cmode,
   input  logic          sync_req,
   input  logic          seq_strobe,
   input  logic          cof_valid,
   input  logic          cof_indirect,
   input  logic          cof_comp,
   input  logic [AW-1:0] cof_target,
   output logic          msg_valid,
   output logic [2:0]    msg_type,
   output logic [AW-1:0] msg_addr,
   output logic [LW-1:0] msg_len,
   output logic [CW-1:0] msg_count
);
   if (AW < 2) begin : g_bad_aw
      $error("AW must be at least 2");
   end
   if (MAXSEQ < 2) begin : g_bad_maxseq
      $error("MAXSEQ must be at least 2");
   end

   logic          emit, pend, seq_wrap;
   logic [CW-1:0] cnt;
   logic [AW-1:0] ref_q, trim_val, trim_addr;
   logic [LW-1:0] trim_len;

   assign emit     = cof_valid & trace_en;
   assign trim_val = pend ? cof_target : (cof_target ^ ref_q);

   brtrace_sync_pend u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .trace_en  (trace_en),
      .unit_off  (unit_off),
      .evt_ctrl  (evt_ctrl),
      .evt_in    (evt_in),
      .wpt_hit   (wpt_hit),
      .q_overrun (q_overrun),
      .cmode     (cmode),
      .sync_req  (sync_req),
      .seq_wrap  (seq_wrap),
      .emit      (emit),
      .pend      (pend)
   );

   brtrace_seq_cnt #(.MAXSEQ(MAXSEQ), .CW(CW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (trace_en),
      .strobe (seq_strobe),
      .clr    (emit),
      .cnt    (cnt),
      .wrap   (seq_wrap)
   );

   brtrace_addr_trim #(.AW(AW), .LW(LW)) u_trim (
      .val  (trim_val),
      .tgt  (cof_target),
      .len  (trim_len),
      .addr (trim_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg_type  <= '0;
         msg_addr  <= '0;
         msg_len   <= '0;
         msg_count <= '0;
         ref_q     <= '0;
      end else begin
         msg_valid <= emit;
         if (emit) begin
            msg_type  <= make_type(pend, cof_kind_e'({cof_comp, cof_indirect}));
            msg_addr  <= trim_addr;
            msg_len   <= trim_len;
            msg_count <= cnt;
            if (pend) ref_q <= cof_target;
         end
      end
   end

   // R11: a message only follows an enabled change of flow
   p_valid_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> ($past(trace_en) && $past(cof_valid)));

   // R2: a sync message matches the reference it installs
   p_sync_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_type[2]) |-> (msg_addr == ref_q));

   // R3: a normal message has no bits at or above its length
   p_norm_trim_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_type[2]) |-> ((msg_addr >> msg_len) == '0));

endmodule

// File: tb/brtrace_sync_ctrl_test.sv
`timescale 1ns/1ps
module brtrace_sync_ctrl_test;
   localparam int AW = 16;
   localparam int MS = 256;

   logic clk = 0, rst_n = 0;
   logic trace_en = 0, unit_off = 0, evt_in = 0, wpt_hit = 0, q_overrun = 0;
   logic cmode = 0, sync_req = 0, seq_strobe = 0;
   logic cof_valid = 0, cof_indirect = 0, cof_comp = 0;
   logic [1:0]    evt_ctrl = 2'b00;
   logic [AW-1:0] cof_target = '0;
   logic          msg_valid;
   logic [2:0]    msg_type;
   logic [AW-1:0] msg_addr;
   logic [4:0]    msg_len;
   logic [7:0]    msg_count;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   brtrace_sync_ctrl #(.AW(AW), .MAXSEQ(MS)) uut (.*);

   // {indirect, comp, target, sync, addr, len}
   localparam logic [39:0] TBL [5] = '{
      {1'b0, 1'b0, 16'h1234, 1'b1, 16'h1234, 5'd13},
      {1'b1, 1'b0, 16'h1238, 1'b0, 16'h0008, 5'd4},
      {1'b0, 1'b1, 16'h1234, 1'b0, 16'h0000, 5'd0},
      {1'b1, 1'b1, 16'h9234, 1'b0, 16'h9234, 5'd16},
      {1'b0, 1'b0, 16'h0001, 1'b0, 16'h0001, 5'd13}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cof(input logic ind, input logic comp, input logic [AW-1:0] tgt,
                      input logic same_req, input logic same_stb);
      @(negedge clk);
      cof_valid = 1; cof_indirect = ind; cof_comp = comp; cof_target = tgt;
      sync_req = same_req; seq_strobe = same_stb;
      @(negedge clk);
      cof_valid = 0; sync_req = 0; seq_strobe = 0;
   endtask

   task automatic strobes(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); seq_strobe = 1;
      end
      @(negedge clk); seq_strobe = 0;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: evt_in = 1;
         1: wpt_hit = 1;
         2: q_overrun = 1;
         default: sync_req = 1;
      endcase
      @(negedge clk);
      evt_in = 0; wpt_hit = 0; q_overrun = 0; sync_req = 0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R1 valid in reset", msg_valid, 0);
      trace_en = 1; rst_n = 1;
      @(negedge clk);
      chk("R1 valid after reset", msg_valid, 0);

      // R1 R2 R3 R12: table walk
      for (int k = 0; k < 5; k++) begin
         cof(TBL[k][39], TBL[k][38], TBL[k][37:22], 0, 0);
         chk("R12 valid", msg_valid, 1);
         chk("R12 type", msg_type, {TBL[k][21], TBL[k][38], TBL[k][39]});
         chk(TBL[k][21] ? "R2 addr" : "R3 addr", msg_addr, TBL[k][20:5]);
         chk(TBL[k][21] ? "R2 len" : "R3 len", msg_len, TBL[k][4:0]);
         chk("R13 count", msg_count, 0);
      end

      // R13: count of strobes, same-cycle strobe goes to the next message
      strobes(5);
      cof(0, 0, 16'h1234, 0, 0);
      chk("R13 count five", msg_count, 5);
      chk("R3 equal len", msg_len, 0);
      cof(0, 0, 16'h1234, 0, 1);
      chk("R13 same-cycle count", msg_count, 0);
      cof(0, 0, 16'h1234, 0, 0);
      chk("R13 carried count", msg_count, 1);

      // R4: request in the cof cycle applies to the following message
      cof(0, 0, 16'h1234, 1, 0);
      chk("R4 not immediate", msg_type[2], 0);
      cof(1, 0, 16'h00F0, 0, 0);
      chk("R4 next is sync", msg_type[2], 1);
      chk("R2 sync addr", msg_addr, 16'h00F0);
      chk("R2 sync len", msg_len, 8);
      cof(0, 0, 16'h00F3, 0, 0);
      chk("R2 new reference len", msg_len, 2);

      // R10
      pulse(3);
      cof(0, 0, 16'h00F0, 0, 0);
      chk("R10 sync after request", msg_type[2], 1);

      // R5: event-in gating
      evt_ctrl = 2'b01; pulse(0);
      cof(0, 0, 16'h00F0, 0, 0);
      chk("R5 evt_ctrl nonzero ignored", msg_type[2], 0);
      evt_ctrl = 2'b00; unit_off = 1; pulse(0);
      cof(0, 0, 16'h00F0, 0, 0);
      chk("R5 unit off ignored", msg_type[2], 0);
      unit_off = 0; pulse(0);
      cof(0, 0, 16'h00F0, 0, 0);
      chk("R5 event-in sync", msg_type[2], 1);

      // R6 R7
      pulse(1);
      cof(0, 0, 16'h00F0, 0, 0);
      chk("R6 watchpoint sync", msg_type[2], 1);
      pulse(2);
      cof(0, 0, 16'h00F0, 0, 0);
      chk("R7 overrun sync", msg_type[2], 1);

      // R9: both directions of mode change
      @(negedge clk); cmode = 1;
      cof(0, 1, 16'h00F0, 0, 0);
      chk("R9 enter sync", msg_type[2], 1);
      cof(0, 1, 16'h00F0, 0, 0);
      chk("R9 steady normal", msg_type[2], 0);
      @(negedge clk); cmode = 0;
      cof(0, 0, 16'h00F0, 0, 0);
      chk("R9 leave sync", msg_type[2], 1);

      // R8: counter wrap boundary
      strobes(MS - 1);
      cof(0, 0, 16'h00F0, 0, 0);
      chk("R8 below max no sync", msg_type[2], 0);
      chk("R8 below max count", msg_count, MS - 1);
      strobes(MS);
      cof(0, 0, 16'h00F0, 0, 0);
      chk("R8 wrap sync", msg_type[2], 1);
      chk("R8 wrap count", msg_count, 0);

      // R11: disabled trace emits nothing, restart is a sync
      @(negedge clk); trace_en = 0;
      cof(0, 0, 16'h00F0, 0, 0);
      chk("R11 disabled no message", msg_valid, 0);
      @(negedge clk); trace_en = 1;
      cof(1, 1, 16'h0ABC, 0, 0);
      chk("R11 restart valid", msg_valid, 1);
      chk("R11 restart sync", msg_type, 3'b111);
      chk("R2 restart addr", msg_addr, 16'h0ABC);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule